// File: doc/BRIEF.md
# Shadowed Multi-Channel PWM Controller

This block generates several independent pulse-width-modulated outputs from one shared timing strobe. Each channel counts prescaled ticks across a programmable period. Its output is active during the first part of the period and inactive for the rest. Each channel has a clock-divide setting of 1, 2, 4 or 8 and a polarity setting. Software programs the channels through a plain memory-mapped port with a write strobe. Reads are combinational.

All writes land in shadow storage first. A channel that is already running does not use new settings until software writes its period register and the period in progress ends. At that boundary, divider, polarity, duty and period change together, so no period ever mixes old and new values. Writing a period of zero stops a channel cleanly. The period in progress runs to its end, and the output then stays low. An idle channel starts at once when it receives a nonzero period.

Top module: `pwm_bank`

## Requirements
- R1: Per channel c (0..3), the period register is at byte address 0x400+4c, the duty register at 0x420+4c and the control register at 0x440+4c. The address must match exactly. Reads return the last value written: the low 16 bits for period and duty, and bits [1:0] and bit 5 for control, with all other bits reading 0. Any other address reads 0.
- R2: While rst_n is low at a rising clock edge, every register is cleared, every channel becomes idle with nothing pending, and every output goes low.
- R3: A running channel with period P and duty D has a cycle of P prescaled counts. With normal polarity the output is high for the first min(D,P) counts and low for the remainder.
- R4: Control bits [1:0] = k make each count last 2^k tick-enabled clock cycles.
- R5: Control bit 5 = 1 inverts the output of a running channel.
- R6: A duty of 0 holds the output inactive for the whole period. A duty equal to or greater than the period holds it active for the whole period.
- R7: Writes to the control or duty register do not change the waveform of a running channel and do not start an idle channel.
- R8: A period write on a running channel arms the shadowed settings. The period in progress finishes with the old settings, and all new settings take effect together from count zero of the next period.
- R9: Writing period 0 lets the period in progress complete. After that the output stays low, whatever the polarity setting, until a nonzero period is written.
- R10: When an idle channel receives a nonzero period write, its output shows count zero of the new configuration two clock cycles after the write edge.
- R11: Counters advance only on cycles with tick_en high. With tick_en low, a running channel's output holds its value.
- R12: Channels run independently. Configuring one channel does not alter another channel's waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Time-base strobe, one clock wide per tick |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 12 | Byte address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
The waveform is measured as high-run and low-run lengths in clock cycles. Each test uses a different combination of divider, duty, period and polarity, so a wrong divider, an off-by-one compare or a missing inversion each give a distinct pair of run lengths. Update timing is tested by writing the period register in the middle of a low phase or a high phase. The length of that run shows whether the old period finished before the switch, and the following runs show that divider and duty changed together. The duty-zero and duty-at-period settings, the gated time base and a period-zero write combined with inverted polarity test the constant-output cases.

// File: rtl/pwmb_pkg.sv
package pwmb_pkg;

   // Which register of a channel an access selects
   typedef enum logic [1:0] {
      RK_NONE = 2'd0,
      RK_PER  = 2'd1,
      RK_DUTY = 2'd2,
      RK_CTRL = 2'd3
   } reg_kind_e;

   // Prescaler counter width needed for a divider select of div_w bits
   function automatic int pre_width(input int div_w);
      return (1 << div_w) - 1;
   endfunction

endpackage

// File: rtl/pwmb_prescale.sv
module pwmb_prescale
   import pwmb_pkg::*;
#(
   parameter int DIV_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic             tick,
   input  logic [DIV_W-1:0] div,
   output logic             step
);
   localparam int PRE_W = pre_width(DIV_W);

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] lim;

   // Terminal count for a 2^div division
   assign lim  = PRE_W'((1 << div) - 1);
   assign step = tick && !hold && (pre_q == lim);

   always_ff @(posedge clk) begin
      if (!rst_n || hold) begin
         pre_q <= '0;
      end else if (tick) begin
         pre_q <= (pre_q == lim) ? '0 : pre_q + PRE_W'(1);
      end
   end
endmodule

// File: rtl/pwmb_regs.sv
module pwmb_regs
   import pwmb_pkg::*;
#(
   parameter int N_CH      = 4,
   parameter int CNT_W     = 16,
   parameter int DIV_W     = 2,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 12,
   parameter int PER_BASE  = 'h400,
   parameter int DUTY_BASE = 'h420,
   parameter int CTRL_BASE = 'h440,
   parameter int STRIDE    = 4,
   parameter int INV_BIT   = 5
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [DATA_W-1:0]           wdata,
   output logic [DATA_W-1:0]           rdata,
   output logic [N_CH-1:0][CNT_W-1:0]  sh_per,
   output logic [N_CH-1:0][CNT_W-1:0]  sh_duty,
   output logic [N_CH-1:0][DIV_W-1:0]  sh_div,
   output logic [N_CH-1:0]             sh_inv,
   output logic [N_CH-1:0]             arm
);
   logic [N_CH-1:0][DATA_W-1:0] rd_vec;
   logic                        unused_wdata;

   assign unused_wdata = ^wdata;

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      reg_kind_e          kind;
      logic [CNT_W-1:0]   per_q;
      logic [CNT_W-1:0]   duty_q;
      logic [DIV_W-1:0]   div_q;
      logic               inv_q;
      logic [DATA_W-1:0]  ctrl_rd;

      always_comb begin
         if (addr == ADDR_W'(PER_BASE + STRIDE * i))       kind = RK_PER;
         else if (addr == ADDR_W'(DUTY_BASE + STRIDE * i)) kind = RK_DUTY;
         else if (addr == ADDR_W'(CTRL_BASE + STRIDE * i)) kind = RK_CTRL;
         else                                              kind = RK_NONE;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            per_q  <= '0;
            duty_q <= '0;
            div_q  <= '0;
            inv_q  <= 1'b0;
         end else if (wr_en) begin
            case (kind)
               RK_PER:  per_q  <= wdata[CNT_W-1:0];
               RK_DUTY: duty_q <= wdata[CNT_W-1:0];
               RK_CTRL: begin
                  div_q <= wdata[DIV_W-1:0];
                  inv_q <= wdata[INV_BIT];
               end
               default: ;
            endcase
         end
      end

      always_comb begin
         ctrl_rd              = '0;
         ctrl_rd[DIV_W-1:0]   = div_q;
         ctrl_rd[INV_BIT]     = inv_q;
      end

      always_comb begin
         case (kind)
            RK_PER:  rd_vec[i] = DATA_W'(per_q);
            RK_DUTY: rd_vec[i] = DATA_W'(duty_q);
            RK_CTRL: rd_vec[i] = ctrl_rd;
            default: rd_vec[i] = '0;
         endcase
      end

      assign sh_per[i]  = per_q;
      assign sh_duty[i] = duty_q;
      assign sh_div[i]  = div_q;
      assign sh_inv[i]  = inv_q;
      assign arm[i]     = wr_en && (kind == RK_PER);
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < N_CH; i++) rdata = rdata | rd_vec[i];
   end
endmodule

// File: rtl/pwmb_chan.sv
module pwmb_chan #(
   parameter int CNT_W = 16,
   parameter int DIV_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             arm,
   input  logic [DIV_W-1:0] sh_div,
   input  logic             sh_inv,
   input  logic [CNT_W-1:0] sh_duty,
   input  logic [CNT_W-1:0] sh_per,
   output logic             pwm,
   output logic             running,
   output logic             pending,
   output logic             wrap
);
   logic [CNT_W-1:0] per_q;
   logic [CNT_W-1:0] duty_q;
   logic [CNT_W-1:0] cnt_q;
   logic [DIV_W-1:0] div_q;
   logic             inv_q;
   logic             pend_q;
   logic             step;
   logic             load;

   assign running = |per_q;
   assign pending = pend_q;

   pwmb_prescale #(.DIV_W(DIV_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (!running),
      .tick  (tick),
      .div   (div_q),
      .step  (step)
   );

   // Last count of the period in progress
   assign wrap = step && (cnt_q == per_q - CNT_W'(1));
   // Shadow transfer: at a period boundary, or at once when idle
   assign load = pend_q && (wrap || !running);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         per_q  <= '0;
         duty_q <= '0;
         div_q  <= '0;
         inv_q  <= 1'b0;
         cnt_q  <= '0;
      end else if (load) begin
         per_q  <= sh_per;
         duty_q <= sh_duty;
         div_q  <= sh_div;
         inv_q  <= sh_inv;
         cnt_q  <= '0;
      end else if (step) begin
         cnt_q  <= wrap ? '0 : cnt_q + CNT_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    pend_q <= 1'b0;
      else if (arm)  pend_q <= 1'b1;
      else if (load) pend_q <= 1'b0;
   end

   assign pwm = running && ((cnt_q < duty_q) ^ inv_q);
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank #(
   parameter int N_CH      = 4,
   parameter int CNT_W     = 16,
   parameter int DIV_W     = 2,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 12,
   parameter int PER_BASE  = 'h400,
   parameter int DUTY_BASE = 'h420,
   parameter int CTRL_BASE = 'h440,
   parameter int STRIDE    = 4,
   parameter int INV_BIT   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [N_CH-1:0]   pwm_out
);
   localparam int WIN = STRIDE * N_CH;

   // Elaboration-time parameter checks
   if (N_CH < 1) begin : g_bad_nch
      $error("pwm_bank: N_CH must be at least 1");
   end
   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("pwm_bank: CNT_W must lie in 1..DATA_W");
   end
   if (DIV_W < 1 || DIV_W > 3) begin : g_bad_div
      $error("pwm_bank: DIV_W must lie in 1..3");
   end
   if (INV_BIT < DIV_W || INV_BIT >= DATA_W) begin : g_bad_inv
      $error("pwm_bank: INV_BIT overlaps the divider field or exceeds DATA_W");
   end
   if (PER_BASE + WIN > DUTY_BASE || DUTY_BASE + WIN > CTRL_BASE ||
       CTRL_BASE + WIN > (1 << ADDR_W)) begin : g_bad_map
      $error("pwm_bank: register windows overlap or exceed the address space");
   end

   logic [N_CH-1:0][CNT_W-1:0] sh_per;
   logic [N_CH-1:0][CNT_W-1:0] sh_duty;
   logic [N_CH-1:0][DIV_W-1:0] sh_div;
   logic [N_CH-1:0]            sh_inv;
   logic [N_CH-1:0]            arm;
   logic [N_CH-1:0]            run_vec;
   logic [N_CH-1:0]            pend_vec;
   logic [N_CH-1:0]            wrap_vec;

   pwmb_regs #(
      .N_CH(N_CH), .CNT_W(CNT_W), .DIV_W(DIV_W), .DATA_W(DATA_W),
      .ADDR_W(ADDR_W), .PER_BASE(PER_BASE), .DUTY_BASE(DUTY_BASE),
      .CTRL_BASE(CTRL_BASE), .STRIDE(STRIDE), .INV_BIT(INV_BIT)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .rdata   (rdata),
      .sh_per  (sh_per),
      .sh_duty (sh_duty),
      .sh_div  (sh_div),
      .sh_inv  (sh_inv),
      .arm     (arm)
   );

   for (genvar i = 0; i < N_CH; i++) begin : g_chan
      pwmb_chan #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick    (tick_en),
         .arm     (arm[i]),
         .sh_div  (sh_div[i]),
         .sh_inv  (sh_inv[i]),
         .sh_duty (sh_duty[i]),
         .sh_per  (sh_per[i]),
         .pwm     (pwm_out[i]),
         .running (run_vec[i]),
         .pending (pend_vec[i]),
         .wrap    (wrap_vec[i])
      );
   end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
   parameter int N_CH     = 4,
   parameter int ADDR_W   = 12,
   parameter int PER_BASE = 'h400,
   parameter int STRIDE   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_en,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [N_CH-1:0]   pwm_out,
   input logic [N_CH-1:0]   run_vec,
   input logic [N_CH-1:0]   pend_vec,
   input logic [N_CH-1:0]   wrap_vec
);
   // R2: a reset edge leaves outputs low and channels idle with nothing armed
   p_rst_idle_r2: assert property (@(posedge clk)
      !rst_n |=> (pwm_out == '0) && (run_vec == '0) && (pend_vec == '0));

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      // R8: a period write leaves the channel armed on the next cycle
      p_arm_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && addr == ADDR_W'(PER_BASE + STRIDE * i)) |=> pend_vec[i]);

      // R8: a running channel drops its armed state only at a period end
      p_commit_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(pend_vec[i]) && !pend_vec[i] && $past(run_vec[i]))
         |-> $past(wrap_vec[i]));

      // R9: a channel stops only when its running period has finished
      p_stop_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(run_vec[i]) && !run_vec[i]) |-> $past(wrap_vec[i]));

      // R11: no tick, no change on a running channel's output
      p_hold_notick_r11: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(run_vec[i]) && run_vec[i] && !$past(tick_en))
         |-> $stable(pwm_out[i]));
   end
endmodule

bind pwm_bank pwm_bank_chk #(
   .N_CH(N_CH), .ADDR_W(ADDR_W), .PER_BASE(PER_BASE), .STRIDE(STRIDE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick_en  (tick_en),
   .wr_en    (wr_en),
   .addr     (addr),
   .pwm_out  (pwm_out),
   .run_vec  (run_vec),
   .pend_vec (pend_vec),
   .wrap_vec (wrap_vec)
);

// File: tb/pwm_bank_test.sv
module pwm_bank_test;
   logic        clk     = 1'b0;
   logic        rst_n   = 1'b0;
   logic        tick_en = 1'b0;
   logic        wr_en   = 1'b0;
   logic [11:0] addr    = '0;
   logic [31:0] wdata   = '0;
   wire  [31:0] rdata;
   wire  [3:0]  pwm_out;

   int n_vec = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   pwm_bank uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .rdata   (rdata),
      .pwm_out (pwm_out)
   );

   function automatic logic [11:0] a_per(input int ch);  return 12'(12'h400 + 4 * ch); endfunction
   function automatic logic [11:0] a_duty(input int ch); return 12'(12'h420 + 4 * ch); endfunction
   function automatic logic [11:0] a_ctrl(input int ch); return 12'(12'h440 + 4 * ch); endfunction

   task automatic chk(input string tag, input longint act, input longint exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; addr = '0; wdata = '0;
   endtask

   task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
      @(negedge clk);
      addr = a;
      #1;
      chk(tag, rdata, exp);
      addr = '0;
   endtask

   task automatic wait_lvl(input int ch, input logic lvl);
      do @(negedge clk); while (pwm_out[ch] !== lvl);
   endtask

   task automatic measure(input int ch, output int hi, output int lo);
      wait_lvl(ch, 1'b0);
      wait_lvl(ch, 1'b1);
      hi = 0;
      while (pwm_out[ch] === 1'b1) begin hi++; @(negedge clk); end
      lo = 0;
      while (pwm_out[ch] === 1'b0) begin lo++; @(negedge clk); end
   endtask

   task automatic count_high(input int ch, input int n, output int hi);
      hi = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (pwm_out[ch] === 1'b1) hi++;
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0; tick_en = 1'b1;
      repeat (3) @(negedge clk);
      chk("R2 outputs low in reset", pwm_out, 0);
      rd_chk("R2 period clear", a_per(0), 0);
      rd_chk("R2 duty clear", a_duty(1), 0);
      rd_chk("R2 control clear", a_ctrl(2), 0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_regmap();
      wr(a_ctrl(2), 32'hFFFF_FFFF);
      rd_chk("R1 control readback", a_ctrl(2), 32'h23);
      wr(a_duty(1), 32'h1234_ABCD);
      rd_chk("R1 duty readback", a_duty(1), 32'hABCD);
      rd_chk("R1 unmapped 0x410", 12'h410, 0);
      rd_chk("R1 unmapped 0x460", 12'h460, 0);
      rd_chk("R1 unaligned 0x441", 12'h441, 0);
      chk("R7 shadow writes leave idle outputs low", pwm_out, 0);
   endtask

   task automatic t_basic();
      int hi, lo;
      wr(a_ctrl(0), 0); wr(a_duty(0), 3); wr(a_per(0), 8);
      measure(0, hi, lo);
      chk("R3 high run div1 d3 p8", hi, 3);
      chk("R3 low run div1 d3 p8", lo, 5);
   endtask

   task automatic t_prescale();
      int hi, lo;
      wr(a_ctrl(1), 2); wr(a_duty(1), 2); wr(a_per(1), 5);
      measure(1, hi, lo);
      chk("R4 high run div4 d2 p5", hi, 8);
      chk("R4 low run div4 d2 p5", lo, 12);
   endtask

   task automatic t_polarity();
      int hi, lo;
      wr(a_ctrl(2), 32'h21); wr(a_duty(2), 2); wr(a_per(2), 6);
      measure(2, hi, lo);
      chk("R5 inverted high run div2 d2 p6", hi, 8);
      chk("R5 inverted low run div2 d2 p6", lo, 4);
      measure(1, hi, lo);
      chk("R12 ch1 high run unchanged", hi, 8);
      chk("R12 ch1 low run unchanged", lo, 12);
   endtask

   task automatic t_extremes();
      int hi;
      wr(a_ctrl(3), 0); wr(a_duty(3), 0); wr(a_per(3), 4);
      repeat (4) @(negedge clk);
      count_high(3, 40, hi);
      chk("R6 duty zero never active", hi, 0);
      wr(a_duty(3), 4); wr(a_per(3), 4);
      repeat (10) @(negedge clk);
      count_high(3, 40, hi);
      chk("R6 duty equal period always active", hi, 40);
      wr(a_ctrl(3), 32'h20); wr(a_duty(3), 0); wr(a_per(3), 4);
      repeat (10) @(negedge clk);
      count_high(3, 40, hi);
      chk("R5 R6 inverted duty zero always active", hi, 40);
   endtask

   task automatic t_tick_gate();
      int hi, lo, changes;
      logic [3:0] snap;
      @(negedge clk); tick_en = 1'b0;
      @(negedge clk); snap = pwm_out;
      changes = 0;
      for (int k = 0; k < 30; k++) begin
         @(negedge clk);
         if (pwm_out !== snap) changes++;
      end
      chk("R11 outputs hold without tick", changes, 0);
      tick_en = 1'b1;
      measure(1, hi, lo);
      chk("R11 ch1 high run after resume", hi, 8);
      chk("R11 ch1 low run after resume", lo, 12);
   endtask

   task automatic t_shadow();
      int hi, lo;
      wr(a_duty(0), 6); wr(a_ctrl(0), 1);
      measure(0, hi, lo);
      chk("R7 high run ignores shadow", hi, 3);
      chk("R7 low run ignores shadow", lo, 5);
      rd_chk("R1 duty reads shadow value", a_duty(0), 6);
   endtask

   task automatic t_atomic();
      int lowc, hi, lo;
      wait_lvl(0, 1'b1);
      wait_lvl(0, 1'b0);
      lowc = 1;
      wr_en = 1'b1; addr = a_per(0); wdata = 12;
      @(negedge clk);
      wr_en = 1'b0; addr = '0; wdata = '0;
      while (pwm_out[0] === 1'b0) begin lowc++; @(negedge clk); end
      chk("R8 old period completes", lowc, 5);
      hi = 0;
      while (pwm_out[0] === 1'b1) begin hi++; @(negedge clk); end
      lo = 0;
      while (pwm_out[0] === 1'b0) begin lo++; @(negedge clk); end
      chk("R8 new high run div2 d6 p12", hi, 12);
      chk("R8 new low run div2 d6 p12", lo, 12);
   endtask

   task automatic t_disable();
      int hc, hi;
      wr(a_ctrl(0), 32'h21);
      wait_lvl(0, 1'b0);
      wait_lvl(0, 1'b1);
      hc = 1;
      wr_en = 1'b1; addr = a_per(0); wdata = 0;
      @(negedge clk);
      wr_en = 1'b0; addr = '0; wdata = '0;
      while (pwm_out[0] === 1'b1) begin hc++; @(negedge clk); end
      chk("R9 running period completes", hc, 12);
      count_high(0, 60, hi);
      chk("R9 output low after stop despite inversion", hi, 0);
      rd_chk("R1 period reads zero", a_per(0), 0);
   endtask

   task automatic t_restart();
      int hi, lo;
      wr(a_ctrl(0), 1);
      count_high(0, 10, hi);
      chk("R7 control write does not start idle channel", hi, 0);
      wr(a_per(0), 12);
      @(negedge clk);
      chk("R10 idle channel starts two cycles after write", pwm_out[0], 1);
      measure(0, hi, lo);
      chk("R10 high run after start", hi, 12);
      chk("R10 low run after start", lo, 12);
   endtask

   task automatic t_reset_midrun();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      chk("R2 reset clears running outputs", pwm_out, 0);
      rd_chk("R2 reset clears period", a_per(1), 0);
      rd_chk("R2 reset clears control", a_ctrl(2), 0);
      @(negedge clk); rst_n = 1'b1;
      repeat (20) @(negedge clk);
      chk("R2 outputs stay low after reset", pwm_out, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_regmap();
      t_basic();
      t_prescale();
      t_polarity();
      t_extremes();
      t_tick_gate();
      t_shadow();
      t_atomic();
      t_disable();
      t_restart();
      t_reset_midrun();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule